// File: doc/BRIEF.md
# Codec Power-Up Configuration Sequencer

This block brings an audio codec out of power-off and loads its control registers without any software involvement. After reset it turns on the analog and amplifier supplies and keeps mute inactive. It holds the codec's hardware reset line low for a fixed settling time, then releases it and waits the same time again. It then issues a fixed program of register writes through the request port of a three-wire control-bus master. Each write is handed to the master and the next one is held back until the master reports completion.

The program begins with a soft-reset handshake. A status write carries the reset bit, the hardware reset line is pulsed low, and the status write is repeated with the reset bit clear. Two further status writes follow, then three direct data writes: volume, tone, and a mode write with the peak-detect position bit set. Six extended registers are then written, each as a two-byte transfer on the data address. When the last write completes, a done flag rises and stays high until the next reset.

Top module: `codec_boot_seq`

## Requirements
- R1: While reset is asserted, `pwr_analog_en`, `pwr_amp_en`, `codec_rst_n`, `req_valid` and `done` are all low, and `mute` is always low.
- R2: Both power enables rise in the first cycle after reset is released and stay high until the next reset.
- R3: `codec_rst_n` stays low for WAIT_CYC = (CLK_HZ/1000)*WAIT_MS cycles after the power enables rise, and rises in cycle WAIT_CYC+1 after reset release.
- R4: The first request appears WAIT_CYC cycles after `codec_rst_n` rises, in cycle 2*WAIT_CYC+1 after reset release.
- R5: `req_valid` is a one-cycle pulse. The request fields stay stable until `xfer_done` is sampled high. The next request appears in the cycle after the edge that samples `xfer_done`. The address byte is {DEV_ADDR[5:0], sel}, with sel = 2'b10 for the status register and 2'b00 for the data register.
- R6: The first write goes to status with byte 0x62: bit 7 = 0, reset bit 6 = 1, clock field bits 5:4 = 10 (256 times the sample rate), format bits 3:1 = 001 (16-bit LSB-justified). When its completion is sampled, `codec_rst_n` goes low for PULSE_CYC cycles, and the next request follows the cycle after it returns high.
- R7: The next three writes go to status with bytes 0x22 (reset bit clear), 0x22, and 0xE0. In 0xE0, bit 7 selects the second status register, bit 6 is output gain and bit 5 is input gain.
- R8: Three single-byte data writes follow, in this order:
  - 0x00: prefix 00, volume 100 percent encoded as attenuation (100-pct)*63/100 = 0.
  - 0x40: prefix 01, bass bits 5:2 = 0, treble bits 1:0 = 0.
  - 0xA0: prefix 10, peak position bit 5 = 1.
- R9: Six extended writes follow, for index 0 to 5 in order. Each is a two-byte transfer (`req_two` = 1) to the data address. The first byte is 0xC0 | index; the second is 0xE0 | value, with values 4, 4, 30, 0, 0, 0. Only these writes use two bytes.
- R10: `xfer_done` has no effect when no request is outstanding: during the power waits, during the reset pulse, and after done.
- R11: `done` rises in the cycle after the edge that samples the last completion, stays high until reset, and no request is issued while it is high.
- R12: Asserting reset after completion returns all outputs to the reset state, and the full sequence repeats with identical timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_done | input | 1 | Completion pulse from the control-bus master |
| req_valid | output | 1 | One-cycle request strobe to the master |
| req_addr | output | 8 | Address byte: device address and register select |
| req_two | output | 1 | 1 = two data bytes, 0 = one |
| req_byte0 | output | 8 | First data byte |
| req_byte1 | output | 8 | Second data byte (zero for single-byte writes) |
| pwr_analog_en | output | 1 | Codec analog supply enable |
| pwr_amp_en | output | 1 | Audio amplifier supply enable |
| mute | output | 1 | Mute control, held inactive low |
| codec_rst_n | output | 1 | Codec hardware reset, active low |
| done | output | 1 | Configuration complete, sticky |

## Verification
The hardest situations to reach from the ports are completion pulses that arrive when nothing is outstanding, above all inside the short hardware reset pulse between the two soft-reset writes. A stray completion there would skip the rest of the pulse or advance the program. The bench injects stray pulses at chosen cycles: during the power wait, during the release wait, one cycle into the reset pulse, and after done. A cycle-accurate model expects no change at any of them. Completion latency varies per write, and between two runs separated by a reset, so request timing and hold behaviour are exercised under different gaps.

// File: rtl/codec_boot_pkg.sv
package codec_boot_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_PWR_WAIT,
        ST_REL_WAIT,
        ST_ISSUE,
        ST_WAIT_ACK,
        ST_RST_PULSE,
        ST_DONE
    } boot_state_e;

    typedef enum logic [1:0] {
        SEL_DATA   = 2'b00,
        SEL_STATUS = 2'b10
    } ctl_sel_e;

    typedef struct packed {
        ctl_sel_e    sel;
        logic        two;
        logic [7:0]  b0;
        logic [7:0]  b1;
    } ctl_cmd_t;

    localparam int NUM_CMDS  = 13;
    localparam int IDX_W     = $clog2(NUM_CMDS);
    localparam int EXT_FIRST = 7;

    localparam logic [1:0] SYSCLK_256FS = 2'b10;
    localparam logic [2:0] FMT_LSB16    = 3'b001;

    function automatic logic [7:0] stat0_byte(logic srst);
        return {1'b0, srst, SYSCLK_256FS, FMT_LSB16, 1'b0};
    endfunction

    function automatic logic [7:0] stat1_byte(logic out_gain, logic in_gain);
        return {1'b1, out_gain, in_gain, 5'b0};
    endfunction

    function automatic logic [7:0] vol_byte(int pct);
        int att;
        att = ((100 - pct) * 63) / 100;
        return {2'b00, 6'(att)};
    endfunction

    function automatic logic [7:0] tone_byte(logic [3:0] bass, logic [1:0] treble);
        return {2'b01, bass, treble};
    endfunction

    function automatic logic [7:0] mode_byte(logic peak_pos);
        return {2'b10, peak_pos, 5'b0};
    endfunction

    function automatic logic [7:0] ext_addr_byte(logic [2:0] idx);
        return {5'b11000, idx};
    endfunction

    function automatic logic [7:0] ext_data_byte(logic [4:0] val);
        return {3'b111, val};
    endfunction

    function automatic logic [4:0] ext_value(int i);
        case (i)
            0, 1:    return 5'd4;
            2:       return 5'd30;
            default: return 5'd0;
        endcase
    endfunction

    function automatic ctl_cmd_t cmd_entry(int i);
        ctl_cmd_t c;
        c     = '0;
        c.sel = SEL_DATA;
        case (i)
            0:    begin c.sel = SEL_STATUS; c.b0 = stat0_byte(1'b1); end
            1, 2: begin c.sel = SEL_STATUS; c.b0 = stat0_byte(1'b0); end
            3:    begin c.sel = SEL_STATUS; c.b0 = stat1_byte(1'b1, 1'b1); end
            4:    c.b0 = vol_byte(100);
            5:    c.b0 = tone_byte(4'd0, 2'd0);
            6:    c.b0 = mode_byte(1'b1);
            default: begin
                if (i >= EXT_FIRST && i < NUM_CMDS) begin
                    c.two = 1'b1;
                    c.b0  = ext_addr_byte(3'(i - EXT_FIRST));
                    c.b1  = ext_data_byte(ext_value(i - EXT_FIRST));
                end
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/codec_boot_timer.sv
module codec_boot_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    p_load_takes_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/codec_boot_cmdrom.sv
module codec_boot_cmdrom
    import codec_boot_pkg::*;
#(
    parameter logic [5:0] DEV_ADDR = 6'h05
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       addr_byte,
    output ctl_cmd_t         cmd
);
    localparam int DEPTH = 2 ** IDX_W;

    ctl_cmd_t cmd_tab [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        if (g < NUM_CMDS) begin : g_used
            assign cmd_tab[g] = cmd_entry(g);
        end else begin : g_pad
            assign cmd_tab[g] = '0;
        end
    end

    always_comb begin
        cmd       = cmd_tab[idx];
        addr_byte = {DEV_ADDR, cmd.sel};
    end
endmodule

// File: rtl/codec_boot_seq.sv
module codec_boot_seq
    import codec_boot_pkg::*;
#(
    parameter int         CLK_HZ    = 100_000_000,
    parameter int         WAIT_MS   = 100,
    parameter int         PULSE_CYC = 16,
    parameter logic [5:0] DEV_ADDR  = 6'h05
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       xfer_done,
    output logic       req_valid,
    output logic [7:0] req_addr,
    output logic       req_two,
    output logic [7:0] req_byte0,
    output logic [7:0] req_byte1,
    output logic       pwr_analog_en,
    output logic       pwr_amp_en,
    output logic       mute,
    output logic       codec_rst_n,
    output logic       done
);
    localparam int WAIT_CYC = (CLK_HZ / 1000) * WAIT_MS;
    localparam int TMAX     = (WAIT_CYC > PULSE_CYC) ? WAIT_CYC : PULSE_CYC;
    localparam int CW       = $clog2(TMAX + 1);
    localparam logic [CW-1:0]    WAIT_LD  = CW'(WAIT_CYC - 1);
    localparam logic [CW-1:0]    PULSE_LD = CW'(PULSE_CYC - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CMDS - 1);

    boot_state_e      state_q, state_nxt;
    logic [IDX_W-1:0] idx_q, idx_nxt;
    logic             t_load, t_expired;
    logic [CW-1:0]    t_val;
    logic [7:0]       rom_addr;
    ctl_cmd_t         rom_cmd;

    codec_boot_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    codec_boot_cmdrom #(.DEV_ADDR(DEV_ADDR)) u_rom (
        .idx       (idx_nxt),
        .addr_byte (rom_addr),
        .cmd       (rom_cmd)
    );

    always_comb begin
        state_nxt = state_q;
        idx_nxt   = idx_q;
        t_load    = 1'b0;
        t_val     = WAIT_LD;
        case (state_q)
            ST_OFF: begin
                state_nxt = ST_PWR_WAIT;
                t_load    = 1'b1;
            end
            ST_PWR_WAIT: if (t_expired) begin
                state_nxt = ST_REL_WAIT;
                t_load    = 1'b1;
            end
            ST_REL_WAIT: if (t_expired) state_nxt = ST_ISSUE;
            ST_ISSUE:    state_nxt = ST_WAIT_ACK;
            ST_WAIT_ACK: if (xfer_done) begin
                if (idx_q == '0) begin
                    state_nxt = ST_RST_PULSE;
                    idx_nxt   = idx_q + 1'b1;
                    t_load    = 1'b1;
                    t_val     = PULSE_LD;
                end else if (idx_q == LAST_IDX) begin
                    state_nxt = ST_DONE;
                end else begin
                    state_nxt = ST_ISSUE;
                    idx_nxt   = idx_q + 1'b1;
                end
            end
            ST_RST_PULSE: if (t_expired) state_nxt = ST_ISSUE;
            ST_DONE:      state_nxt = ST_DONE;
            default:      state_nxt = ST_OFF;
        endcase
    end

    // Outputs are registered from the next state so that pins change
    // together with the state register and never glitch.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_OFF;
            idx_q         <= '0;
            req_valid     <= 1'b0;
            req_addr      <= '0;
            req_two       <= 1'b0;
            req_byte0     <= '0;
            req_byte1     <= '0;
            pwr_analog_en <= 1'b0;
            pwr_amp_en    <= 1'b0;
            codec_rst_n   <= 1'b0;
            done          <= 1'b0;
        end else begin
            state_q       <= state_nxt;
            idx_q         <= idx_nxt;
            req_valid     <= (state_nxt == ST_ISSUE);
            req_addr      <= rom_addr;
            req_two       <= rom_cmd.two;
            req_byte0     <= rom_cmd.b0;
            req_byte1     <= rom_cmd.two ? rom_cmd.b1 : 8'h00;
            pwr_analog_en <= (state_nxt != ST_OFF);
            pwr_amp_en    <= (state_nxt != ST_OFF);
            codec_rst_n   <= !(state_nxt inside {ST_OFF, ST_PWR_WAIT, ST_RST_PULSE});
            done          <= (state_nxt == ST_DONE);
        end
    end

    assign mute = 1'b0;

    p_req_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid);
    p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_ACK && !xfer_done) |=>
        ($stable(req_addr) && $stable(req_byte0) && $stable(req_byte1) && $stable(req_two)));
    p_power_first_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(codec_rst_n) |-> (pwr_analog_en && pwr_amp_en));
    p_req_out_of_reset_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> codec_rst_n);
    p_two_on_data_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_two) |-> (req_addr[1:0] == SEL_DATA));
    p_done_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> done);
    p_quiet_after_done_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_valid);
endmodule

// File: tb/codec_boot_seq_bench.sv
module codec_boot_seq_bench;
    localparam int CLK_HZ = 20_000;
    localparam int WMS    = 100;
    localparam int W      = (CLK_HZ / 1000) * WMS;
    localparam int P      = 4;
    localparam int NCMD   = 13;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       xfer_done = 1'b0;
    logic       req_valid, req_two, pwr_analog_en, pwr_amp_en, mute, codec_rst_n, done;
    logic [7:0] req_addr, req_byte0, req_byte1;

    always #5 clk = ~clk;

    codec_boot_seq #(.CLK_HZ(CLK_HZ), .WAIT_MS(WMS), .PULSE_CYC(P), .DEV_ADDR(6'h05)) u_codec_boot_seq (
        .clk(clk), .rst(rst), .xfer_done(xfer_done),
        .req_valid(req_valid), .req_addr(req_addr), .req_two(req_two),
        .req_byte0(req_byte0), .req_byte1(req_byte1),
        .pwr_analog_en(pwr_analog_en), .pwr_amp_en(pwr_amp_en), .mute(mute),
        .codec_rst_n(codec_rst_n), .done(done)
    );

    int nchecks = 0, nfail = 0;
    int cyc = 0, k = 0, next_req = 2 * W + 1, ack_edge = 0, pulse_lo = 0, done_at = 0;
    int run = 0, rst_left = 3;
    bit ack_pend = 0, finished = 0;

    task automatic chk(string tag, int act, int exp);
        nchecks++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s cycle=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    function automatic int exp_addr(int i);
        return (i <= 3) ? 8'h16 : 8'h14;
    endfunction

    function automatic int exp_b0(int i);
        case (i)
            0: return 8'h62;
            1, 2: return 8'h22;
            3: return 8'hE0;
            4: return 8'h00;
            5: return 8'h40;
            6: return 8'hA0;
            default: return 8'hC0 + (i - 7);
        endcase
    endfunction

    function automatic int exp_b1(int i);
        case (i)
            7, 8: return 8'hE4;
            9: return 8'hFE;
            10, 11, 12: return 8'hE0;
            default: return 0;
        endcase
    endfunction

    function automatic int latency(int i);
        return (run == 0) ? 2 + (i % 4) : 2 + ((i * 5 + 1) % 7);
    endfunction

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        finished = 1;
        $finish;
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            if (rst) begin
                cyc = 0; k = 0; next_req = 2 * W + 1; ack_pend = 0; pulse_lo = 0; done_at = 0;
                chk("R1 pwr_analog_en", pwr_analog_en, 0);
                chk("R1 pwr_amp_en", pwr_amp_en, 0);
                chk("R1 codec_rst_n", codec_rst_n, 0);
                chk("R1 req_valid", req_valid, 0);
                chk(run ? "R12 done cleared" : "R1 done", done, 0);
            end else begin
                cyc++;
                if (ack_pend && cyc == ack_edge) begin
                    ack_pend = 0;
                    if (k == 0) begin pulse_lo = cyc; next_req = cyc + P; end
                    else next_req = cyc;
                    if (k == NCMD - 1) done_at = cyc;
                    k++;
                end
                begin
                    bit in_pulse, e_req, e_rstn, e_done;
                    in_pulse = (pulse_lo > 0) && (cyc >= pulse_lo) && (cyc < pulse_lo + P);
                    e_rstn   = (cyc >= W + 1) && !in_pulse;
                    e_req    = (k < NCMD) && (cyc == next_req);
                    e_done   = (done_at > 0) && (cyc >= done_at);
                    chk("R2 pwr_analog_en", pwr_analog_en, 1);
                    chk("R2 pwr_amp_en", pwr_amp_en, 1);
                    chk("R1 mute", mute, 0);
                    chk(in_pulse ? "R6 reset pulse" : "R3 codec_rst_n", codec_rst_n, e_rstn);
                    chk((k == 0) ? "R4 first request" : "R5 request timing R10", req_valid, e_req);
                    chk("R11 done", done, e_done);
                    if (e_req) begin
                        string tg;
                        tg = (k == 0) ? "R6" : (k <= 3) ? "R7" : (k <= 6) ? "R8" : "R9";
                        chk({tg, " addr R5"}, req_addr, exp_addr(k));
                        chk({tg, " byte0"}, req_byte0, exp_b0(k));
                        chk({tg, " two"}, req_two, (k >= 7) ? 1 : 0);
                        if (k >= 7) chk({tg, " byte1"}, req_byte1, exp_b1(k));
                        ack_pend = 1;
                        ack_edge = cyc + latency(k);
                    end
                end
            end

            if (!rst && done_at > 0 && cyc == done_at + 6) begin
                if (run == 0) begin run = 1; rst_left = 2; end
                else finish_run();
            end

            if (!finished) begin
                if (rst_left > 0) begin rst = 1'b1; rst_left--; end
                else rst = 1'b0;
                // R10: stray completions where nothing is outstanding
                xfer_done = !rst && ((ack_pend && cyc + 1 == ack_edge) ||
                            (cyc + 1 == 3) || (cyc + 1 == W + 5) ||
                            (pulse_lo > 0 && k == 1 && cyc + 1 == pulse_lo + 1) ||
                            (done_at > 0 && cyc + 1 == done_at + 2));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired cycle=%0d actual=running expected=finished", cyc);
            finish_run();
        end
    end
endmodule